// File: doc/BRIEF.md
# Local Interrupt Controller Timer

This block is the countdown timer of a per-core local interrupt controller. Software programs a start value, a clock divider setting and a timer entry that holds an interrupt vector, a mask bit and a mode bit. Once a non-zero start value is written, the block counts down on a divided bus clock. When the count expires, it raises an interrupt request that carries the programmed vector. In periodic mode it then reloads and keeps running. In one-shot mode it stops at zero.

A request that is still waiting for acknowledge cannot be raised a second time. Expiries that arrive while a request is pending are therefore counted, not dropped. Each acknowledge uses up one counted expiry and leaves the request asserted. The request falls only when an acknowledge arrives with no expiries left over. A controller-wide enable gates the request. Turning the enable off forces the timer entry to masked. The current count can always be read back.

The counter core has two states. ST_IDLE means stopped, with the count held at zero. ST_RUN means counting. A start-value write moves the core from any state to ST_RUN when the value is non-zero, and to ST_IDLE when it is zero. In ST_RUN, an expiry in one-shot mode returns the core to ST_IDLE. An expiry in periodic mode reloads the count and stays in ST_RUN.

Top module: `lic_timer`

## Requirements
- R1: After reset, the current count reads 0, the interrupt request is low, the timer entry reads 0x0001_0000 (masked), and the controller is disabled.
- R2: The divider setting is a 3-bit code c = {wr_data[3], wr_data[1], wr_data[0]}, and wr_data[2] is ignored. The count period is 2^((c+1) mod 8) clocks, so code 7 divides by 1, code 0 by 2 and code 6 by 128.
- R3: A start-value write of N>0 makes the count read N after that clock edge and resets the divider phase. The count then falls by one every divisor clocks, and expiry comes exactly N×divisor clocks after the write edge.
- R4: In one-shot mode (entry bit 17 clear), the count stays at 0 after expiry and no further request is raised.
- R5: In periodic mode (entry bit 17 set), expiry reloads the start value, and requests recur every N×divisor clocks.
- R6: At expiry, a request is raised with the vector from entry bits 7:0 only if the controller is enabled and the mask (entry bit 16) is clear. Otherwise no request is raised.
- R7: An expiry that arrives while a request is pending is counted. An acknowledge with a non-zero count keeps the request high and decrements the count. An acknowledge with a zero count drops the request. An acknowledge with no request pending has no effect.
- R8: A start-value write of 0 stops the counter at 0 and raises no request.
- R9: A divider write does not take effect until the next divider period boundary.
- R10: A timer entry write keeps only bits 17, 16, 12 and 7:0. All other bits read back 0.
- R11: Writing enable=0 (wr_data[0]) sets the entry mask bit. While the controller is disabled, every entry write reads back with the mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, the timebase |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 32 | Shared write data |
| icnt_wr | input | 1 | Start-value write strobe |
| div_wr | input | 1 | Divider setting write strobe |
| lvt_wr | input | 1 | Timer entry write strobe |
| en_wr | input | 1 | Controller enable write strobe (bit 0) |
| irq_ack | input | 1 | Acknowledge of the timer request |
| ccnt_rd | output | 32 | Current count |
| lvt_rd | output | 32 | Timer entry readback |
| irq_req | output | 1 | Timer interrupt request |
| irq_vec | output | 8 | Vector of the pending request |

## Verification
Directed runs use divider codes 7, 0 and 6 with small start values, and check the expiry cycle against N×divisor. A periodic run confirms the recurrence period. A randomized sweep covers the whole code space, sets the ignored divider bit at random, and mixes masked and unmasked entries. This tells a wrong bit decode apart from a wrong period and separates gating from counting. A divider change issued mid-period expires one cycle later than an immediate change would, which exposes eager loading. Three unacknowledged periodic expiries followed by a stop need exactly three acknowledges to clear the request, which shows that colliding expiries are replayed, not lost.

// File: rtl/lic_timer_pkg.sv
package lic_timer_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_RUN} run_state_e;

    localparam int          ENTRY_W   = 32;
    localparam int          VEC_W     = 8;
    localparam int          MASK_BIT  = 16;
    localparam int          PER_BIT   = 17;
    localparam int          SHIFT_W   = 3;
    localparam logic [31:0] ENTRY_KEEP  = 32'h0003_10FF;
    localparam logic [31:0] ENTRY_RESET = 32'h0001_0000;

    // divider code from bits {3,1,0}; period exponent wraps modulo 8
    function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] cfg);
        logic [SHIFT_W-1:0] code;
        code = {cfg[3], cfg[1], cfg[0]};
        return code + 3'd1;
    endfunction
endpackage

// File: rtl/lic_timer_presc.sv
module lic_timer_presc
    import lic_timer_pkg::*;
#(
    parameter int SHW = SHIFT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           run,
    input  logic [SHW-1:0] shift_cfg,
    output logic           tick
);
    localparam int PRE_W = (1 << SHW) - 1;

    logic [SHW-1:0]  shift_act;
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] limit;

    always_comb begin
        span  = (PRE_W+1)'(1) << shift_act;
        limit = PRE_W'(span - 1'b1);
        tick  = run && (pre_cnt == limit);
    end

    // new setting is only adopted at a period boundary or on restart
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt   <= '0;
            shift_act <= '0;
        end else if (restart || tick) begin
            pre_cnt   <= '0;
            shift_act <= shift_cfg;
        end else if (run) begin
            pre_cnt   <= pre_cnt + 1'b1;
        end else begin
            pre_cnt   <= '0;
        end
    end

    // R9
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !tick) |=> $stable(shift_act));
endmodule

// File: rtl/lic_timer_core.sv
module lic_timer_core
    import lic_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    output logic             run,
    output logic             expire,
    output logic [CNT_W-1:0] ccnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] icnt_q;
    logic             last_step;

    assign last_step = (state_q == ST_RUN) && tick && (ccnt == ONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load && load_val != '0) state_d = ST_RUN;
            ST_RUN: begin
                if (load)                        state_d = (load_val != '0) ? ST_RUN : ST_IDLE;
                else if (last_step && !periodic) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        run    = (state_q == ST_RUN);
        expire = last_step && !load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            icnt_q <= '0;
            ccnt   <= '0;
        end else if (load) begin
            icnt_q <= load_val;
            ccnt   <= load_val;
        end else if (run && tick) begin
            if (ccnt == ONE) ccnt <= periodic ? icnt_q : '0;
            else             ccnt <= ccnt - 1'b1;
        end
    end

    // R8
    zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> (!run && ccnt == '0));
    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && ccnt > ONE) |=> (ccnt == $past(ccnt) - 1'b1));
    // R4
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (ccnt == '0));
    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic) |=> (ccnt == icnt_q && run));
endmodule

// File: rtl/lic_timer_irq.sv
module lic_timer_irq
    import lic_timer_pkg::*;
#(
    parameter int OVF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire,
    input  logic             allow,
    input  logic [VEC_W-1:0] vec,
    input  logic             ack,
    output logic             pend,
    output logic [VEC_W-1:0] vec_q
);
    localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};

    logic [OVF_W-1:0] ovf;
    logic             raise, ack_eff;

    assign raise   = expire && allow;
    assign ack_eff = ack && pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            ovf   <= '0;
            vec_q <= '0;
        end else begin
            unique case ({ack_eff, raise})
                2'b11: if (ovf == '0) vec_q <= vec;
                2'b10: begin
                    if (ovf != '0) ovf  <= ovf - 1'b1;
                    else           pend <= 1'b0;
                end
                2'b01: begin
                    if (pend) begin
                        if (ovf != OVF_MAX) ovf <= ovf + 1'b1;
                    end else begin
                        pend  <= 1'b1;
                        vec_q <= vec;
                    end
                end
                default: ;
            endcase
        end
    end

    // R7
    ovf_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf != '0) |-> pend);
    // R7
    last_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pend && ovf == '0 && !raise) |=> !pend);
    // R6
    raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> pend);
endmodule

// File: rtl/lic_timer.sv
module lic_timer
    import lic_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int OVF_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic               icnt_wr,
    input  logic               div_wr,
    input  logic               lvt_wr,
    input  logic               en_wr,
    input  logic               irq_ack,
    output logic [CNT_W-1:0]   ccnt_rd,
    output logic [ENTRY_W-1:0] lvt_rd,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec
);
    logic [ENTRY_W-1:0] entry_q;
    logic [ENTRY_W-1:0] wr_entry;
    logic [SHIFT_W-1:0] shift_cfg;
    logic               enabled;
    logic               tick, run, expire;

    assign wr_entry = ENTRY_W'(wr_data);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q   <= ENTRY_RESET;
            enabled   <= 1'b0;
            shift_cfg <= div_shift(4'h0);
        end else begin
            if (div_wr) shift_cfg <= div_shift(wr_data[3:0]);
            if (lvt_wr) begin
                entry_q           <= wr_entry & ENTRY_KEEP;
                entry_q[MASK_BIT] <= wr_entry[MASK_BIT] | ~enabled;
            end
            if (en_wr) begin
                enabled <= wr_data[0];
                if (!wr_data[0]) entry_q[MASK_BIT] <= 1'b1;
            end
        end
    end

    lic_timer_presc #(.SHW(SHIFT_W)) presc_i (
        .clk(clk), .rst_n(rst_n), .restart(icnt_wr), .run(run),
        .shift_cfg(shift_cfg), .tick(tick)
    );

    lic_timer_core #(.CNT_W(CNT_W)) core_i (
        .clk(clk), .rst_n(rst_n), .load(icnt_wr), .load_val(wr_data),
        .tick(tick), .periodic(entry_q[PER_BIT]), .run(run),
        .expire(expire), .ccnt(ccnt_rd)
    );

    lic_timer_irq #(.OVF_W(OVF_W)) irq_i (
        .clk(clk), .rst_n(rst_n), .expire(expire),
        .allow(enabled && !entry_q[MASK_BIT]), .vec(entry_q[VEC_W-1:0]),
        .ack(irq_ack), .pend(irq_req), .vec_q(irq_vec)
    );

    assign lvt_rd = entry_q;

    // R11
    dis_entry_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && lvt_wr) |=> lvt_rd[MASK_BIT]);
    // R6
    gated_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && (!enabled || entry_q[MASK_BIT]) && !irq_req) |=> !irq_req);
endmodule

// File: tb/lic_timer_tb_top.sv
module lic_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] wr_data = '0;
    logic        icnt_wr = 0, div_wr = 0, lvt_wr = 0, en_wr = 0, irq_ack = 0;
    logic [31:0] ccnt_rd, lvt_rd;
    logic        irq_req;
    logic [7:0]  irq_vec;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lic_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .icnt_wr(icnt_wr),
        .div_wr(div_wr), .lvt_wr(lvt_wr), .en_wr(en_wr), .irq_ack(irq_ack),
        .ccnt_rd(ccnt_rd), .lvt_rd(lvt_rd), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    function automatic int exp_div(input int code);
        return 1 << ((code + 1) % 8);
    endfunction

    function automatic logic [31:0] code_data(input int code, input logic junk);
        logic [2:0] c;
        c = 3'(code);
        return {28'h0, c[2], junk, c[1], c[0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // 0 icnt, 1 div, 2 lvt, 3 en
    task automatic wr(input int kind, input logic [31:0] d);
        wr_data = d;
        icnt_wr = (kind == 0); div_wr = (kind == 1);
        lvt_wr  = (kind == 2); en_wr  = (kind == 3);
        @(posedge clk); @(negedge clk);
        icnt_wr = 0; div_wr = 0; lvt_wr = 0; en_wr = 0;
    endtask

    task automatic ack();
        irq_ack = 1;
        @(posedge clk); @(negedge clk);
        irq_ack = 0;
    endtask

    task automatic measure(output int k, input int limit);
        k = 0;
        while (!irq_req && k < limit) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic run_all();
        int k;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk("R1 count", ccnt_rd, 0);
        chk("R1 req", {31'h0, irq_req}, 0);
        chk("R1 entry", lvt_rd, 32'h0001_0000);
        // R11 disabled from reset: entry write forced masked
        wr(2, 32'h0000_0033);
        chk("R11 disabled write", lvt_rd, 32'h0001_0033);
        // R6 disabled blocks request
        wr(1, code_data(7, 0)); wr(0, 3);
        repeat (6) @(negedge clk);
        chk("R6 disabled no req", {31'h0, irq_req}, 0);
        wr(3, 1);
        // R10
        wr(2, 32'hFFFF_FFFF);
        chk("R10 field keep", lvt_rd, 32'h0003_10FF);
        wr(2, 32'h0000_00A5);
        wr(3, 0);
        chk("R11 disable masks", lvt_rd, 32'h0001_00A5);
        wr(3, 1);
        wr(2, 32'h0000_00A5);
        // R2 R3 directed
        wr(1, code_data(7, 0)); wr(0, 5);
        chk("R3 load visible", ccnt_rd, 5);
        measure(k, 200);
        chk("R2 R3 code7 period", k, 5);
        chk("R6 vector", {24'h0, irq_vec}, 32'hA5);
        ack();
        chk("R7 single ack drops", {31'h0, irq_req}, 0);
        wr(1, code_data(0, 1)); wr(0, 3);
        measure(k, 200);
        chk("R2 code0 period", k, 6);
        ack();
        // R4
        repeat (30) @(negedge clk);
        chk("R4 oneshot no rearm", {31'h0, irq_req}, 0);
        chk("R4 oneshot count", ccnt_rd, 0);
        wr(1, code_data(6, 0)); wr(0, 1);
        measure(k, 400);
        chk("R2 code6 period", k, 128);
        ack();
        // R5 periodic
        wr(2, 32'h0002_0011);
        wr(1, code_data(0, 0)); wr(0, 3);
        measure(k, 200);
        chk("R5 first period", k, 6);
        ack();
        measure(k, 200);
        chk("R5 second period", k, 5);
        wr(0, 0); ack();
        // R7 overflow replay
        wr(2, 32'h0002_0040);
        wr(1, code_data(7, 0)); wr(0, 2);
        repeat (6) @(negedge clk);
        wr(0, 0);
        chk("R7 pending", {31'h0, irq_req}, 1);
        chk("R7 vector", {24'h0, irq_vec}, 32'h40);
        ack(); chk("R7 replay 1", {31'h0, irq_req}, 1);
        ack(); chk("R7 replay 2", {31'h0, irq_req}, 1);
        ack(); chk("R7 drained", {31'h0, irq_req}, 0);
        ack(); chk("R7 idle ack ignored", {31'h0, irq_req}, 0);
        // R8
        wr(2, 32'h0000_0040);
        wr(0, 5); wr(0, 0);
        repeat (20) @(negedge clk);
        chk("R8 stopped count", ccnt_rd, 0);
        chk("R8 no req", {31'h0, irq_req}, 0);
        // R9 deferred divider
        wr(1, code_data(0, 0)); wr(0, 4);
        wr(1, code_data(7, 0));
        measure(k, 200);
        chk("R9 deferred divider", k + 1, 5);
        ack();
        // R6 masked
        wr(2, 32'h0001_0055);
        wr(1, code_data(7, 0)); wr(0, 4);
        repeat (10) @(negedge clk);
        chk("R6 masked no req", {31'h0, irq_req}, 0);
        chk("R6 masked count done", ccnt_rd, 0);
        // random sweep
        for (int t = 0; t < 12; t++) begin
            int code, n, d;
            logic msk;
            logic [7:0] v;
            code = int'($urandom % 8);
            n    = 1 + int'($urandom % 12);
            msk  = ($urandom % 4) == 0;
            v    = 8'($urandom);
            d    = exp_div(code);
            wr(2, {15'h0, msk, 8'h0, v});
            wr(1, code_data(code, 1'($urandom)));
            wr(0, 32'(n));
            if (msk) begin
                repeat (n * d + 2) @(negedge clk);
                chk("R6 random masked", {31'h0, irq_req}, 0);
                chk("R4 random masked count", ccnt_rd, 0);
            end else begin
                measure(k, n * d + 10);
                chk("R2 R3 random period", k, n * d);
                chk("R6 random vector", {24'h0, irq_vec}, {24'h0, v});
                ack();
            end
        end
    endtask

    task automatic watchdog();
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual 1 expected 0");
    endtask

    initial begin
        fork
            run_all();
            watchdog();
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule